// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Unit

This unit keeps the interrupt cause, status and sequence-step registers of a disk-bus host adapter and drives its level interrupt line. Neighbouring logic in the adapter uses a few event strobes to report what happened. It can load new cause, status and step values, report a command completion together with its status byte, or signal a bus reset. An event may also ask for the interrupt to be raised. Bus phase handling and data movement stay outside the unit and are seen here only through those strobes.

The host acknowledges an interrupt by reading the cause register, and that single read has several effects. The old cause value is returned, the cause is cleared, the pending and terminal-count status bits are dropped, the step is set to the command-done code and the line falls. A completion that arrives while an interrupt is still pending cannot be reported at once. Its status byte is parked and replayed the cycle after the acknowledging read, which raises the interrupt again. A configuration register holds a reset-report-disable bit that decides whether a bus reset interrupts the host.

Top module: `intr_status_unit`

## Requirements
- R1: While rstN is low, cause, status, step, readData, doneStatus and irqOut are all zero, and cfg1Out is 8'h07.
- R2: An evtLoad, when no acknowledging read, replay, completion or bus reset wins the cycle, loads evtCause into cause, evtStatus bits 6:0 into status bits 6:0 and evtSeq into the step at the next edge. With evtRaise set, it also raises the interrupt: status bit 7 (the pending bit) goes to 1 and irqOut goes high.
- R3: irqOut always equals status bit 7. A raise request while that bit is already set changes neither of them.
- R4: A host read (hostRd) puts the cause value of that cycle on readData and clears cause to zero at the next edge. readData keeps its value until the next read.
- R5: The same read clears status bit 7 and status bit 4 (terminal count), keeps status bits 6:5 and 3:0, sets the step to 3'd4 (command done) and drops irqOut.
- R6: In a cycle with hostRd, the evtLoad and busReset strobes have no effect.
- R7: A cmdDone while status bit 7 is clear and no completion is parked sets status to 8'h93 (pending bit, terminal count and status phase 3'b011), sets cause to 8'h10 (bus service), clears the step, copies cmdByte to doneStatus and raises irqOut.
- R8: A cmdDone while status bit 7 is set, or in a cycle with hostRd, leaves cause, status, step, doneStatus and irqOut unchanged and parks cmdByte.
- R9: When a completion is parked, status bit 7 is clear and hostRd is low, the parked completion is reported exactly as in R7 using the parked byte. This happens on the cycle after an acknowledging read.
- R10: A busReset sets cause to 8'h80. It raises the interrupt only when cfg1Out bit 6 is 0. With the bit set, status and irqOut keep their values.
- R11: A cfgWrite loads cfgData into cfg1Out at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| hostRd | input | 1 | Host read of the cause register (acknowledge) |
| evtLoad | input | 1 | Load cause, status and step from the event fields |
| evtRaise | input | 1 | With evtLoad, request an interrupt |
| evtCause | input | 8 | Cause value for evtLoad |
| evtStatus | input | 8 | Status value for evtLoad (bit 7 ignored) |
| evtSeq | input | 3 | Step value for evtLoad |
| cmdDone | input | 1 | Command completion event |
| cmdByte | input | 8 | Status byte of the completed command |
| busReset | input | 1 | Bus reset command |
| cfgWrite | input | 1 | Write strobe for configuration register 1 |
| cfgData | input | 8 | Data for configuration register 1 |
| irqOut | output | 1 | Level interrupt line |
| causeOut | output | 8 | Interrupt cause register |
| statusOut | output | 8 | Status register |
| seqOut | output | 3 | Sequence step register |
| cfg1Out | output | 8 | Configuration register 1 |
| readData | output | 8 | Cause value returned by the last host read |
| doneStatus | output | 8 | Status byte of the last reported completion |

## Verification
Every register result is due at the first clock edge after the cycle in which its stimulus is driven. A parked completion appears only at the second edge after the acknowledging read, because that read must first clear the pending bit. The driver applies each stimulus just after a falling edge and queues the state the requirements predict for the following rising edge. The monitor compares each queued item 5 ns after that edge, so an item that is one cycle early or late shows up as a mismatch. The replay is therefore checked in the idle cycle that follows the read.

// File: rtl/intr_status_pkg.sv
package intr_status_pkg;

  // status register bit positions
  localparam int INTR_POS = 7;
  localparam int TC_POS   = 4;
  // configuration register 1: reset-report-disable bit
  localparam int RPT_OFF_POS = 6;

  // encodings
  localparam logic [7:0] CFG1_INIT     = 8'h07;
  localparam logic [7:0] CAUSE_SERVICE = 8'h10;
  localparam logic [7:0] CAUSE_BUS_RST = 8'h80;
  localparam logic [7:0] STATUS_DONE   = 8'h13;  // terminal count + status phase
  localparam logic [2:0] SEQ_CMD_DONE  = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic ack;         // host read of the cause register
    logic replay;      // report the parked completion
    logic complete;    // report a fresh completion
    logic busRst;      // bus reset event
    logic load;        // generic event load
    logic cfgLoad;     // configuration write
    logic deferLatch;  // park an incoming completion
    logic raise;       // request the interrupt
  } strobe_t;

endpackage

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl
  import intr_status_pkg::*;
(
  input  logic    hostRd,
  input  logic    evtLoad,
  input  logic    evtRaise,
  input  logic    cmdDone,
  input  logic    busReset,
  input  logic    cfgWrite,
  input  logic    intrSet,
  input  logic    deferPending,
  input  logic    reportOff,
  output strobe_t stb
);

  logic replayNow;
  logic completeNow;
  logic busRstNow;
  logic loadNow;

  // priority: acknowledge > replay > fresh completion > bus reset > load
  always_comb begin
    replayNow   = !hostRd && deferPending && !intrSet;
    completeNow = !hostRd && !deferPending && !intrSet && cmdDone;
    busRstNow   = !hostRd && !replayNow && !completeNow && busReset;
    loadNow     = !hostRd && !replayNow && !completeNow && !busReset && evtLoad;

    stb            = '0;
    stb.ack        = hostRd;
    stb.replay     = replayNow;
    stb.complete   = completeNow;
    stb.busRst     = busRstNow;
    stb.load       = loadNow;
    stb.cfgLoad    = cfgWrite;
    stb.deferLatch = cmdDone && !completeNow;
    stb.raise      = replayNow || completeNow ||
                     (busRstNow && !reportOff) ||
                     (loadNow && evtRaise);
  end

endmodule

// File: rtl/intr_status_dp.sv
module intr_status_dp
  import intr_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEQ_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] evtCause,
  input  logic [DATA_W-1:0] evtStatus,
  input  logic [SEQ_W-1:0]  evtSeq,
  input  logic [DATA_W-1:0] cmdByte,
  input  logic [DATA_W-1:0] cfgData,
  output logic              irqOut,
  output logic [DATA_W-1:0] causeReg,
  output logic [DATA_W-1:0] statusReg,
  output logic [SEQ_W-1:0]  seqReg,
  output logic [DATA_W-1:0] cfg1Reg,
  output logic [DATA_W-1:0] readReg,
  output logic [DATA_W-1:0] doneReg,
  output logic              deferPending
);

  localparam logic [DATA_W-1:0] INTR_MASK = DATA_W'(1) << INTR_POS;

  logic [DATA_W-1:0] deferByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg     <= '0;
      statusReg    <= '0;
      seqReg       <= '0;
      cfg1Reg      <= DATA_W'(CFG1_INIT);
      readReg      <= '0;
      doneReg      <= '0;
      irqOut       <= 1'b0;
      deferPending <= 1'b0;
      deferByte    <= '0;
    end else begin
      if (stb.ack) begin
        readReg           <= causeReg;
        causeReg          <= '0;
        statusReg[INTR_POS] <= 1'b0;
        statusReg[TC_POS] <= 1'b0;
        seqReg            <= SEQ_W'(SEQ_CMD_DONE);
        irqOut            <= 1'b0;
      end else if (stb.replay || stb.complete) begin
        statusReg <= DATA_W'(STATUS_DONE) | (statusReg & INTR_MASK);
        causeReg  <= DATA_W'(CAUSE_SERVICE);
        seqReg    <= '0;
        doneReg   <= stb.replay ? deferByte : cmdByte;
      end else if (stb.busRst) begin
        causeReg <= DATA_W'(CAUSE_BUS_RST);
      end else if (stb.load) begin
        causeReg  <= evtCause;
        statusReg <= (evtStatus & ~INTR_MASK) | (statusReg & INTR_MASK);
        seqReg    <= evtSeq;
      end

      // raise only acts when the pending bit is clear
      if (stb.raise && !statusReg[INTR_POS]) begin
        statusReg[INTR_POS] <= 1'b1;
        irqOut              <= 1'b1;
      end

      if (stb.replay) deferPending <= 1'b0;
      if (stb.deferLatch) begin
        deferPending <= 1'b1;
        deferByte    <= cmdByte;
      end

      if (stb.cfgLoad) cfg1Reg <= cfgData;
    end
  end

endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import intr_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEQ_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              evtLoad,
  input  logic              evtRaise,
  input  logic [DATA_W-1:0] evtCause,
  input  logic [DATA_W-1:0] evtStatus,
  input  logic [SEQ_W-1:0]  evtSeq,
  input  logic              cmdDone,
  input  logic [DATA_W-1:0] cmdByte,
  input  logic              busReset,
  input  logic              cfgWrite,
  input  logic [DATA_W-1:0] cfgData,
  output logic              irqOut,
  output logic [DATA_W-1:0] causeOut,
  output logic [DATA_W-1:0] statusOut,
  output logic [SEQ_W-1:0]  seqOut,
  output logic [DATA_W-1:0] cfg1Out,
  output logic [DATA_W-1:0] readData,
  output logic [DATA_W-1:0] doneStatus
);

  strobe_t stb;
  logic    deferPending;

  intr_status_ctrl uCtrl (
    .hostRd       (hostRd),
    .evtLoad      (evtLoad),
    .evtRaise     (evtRaise),
    .cmdDone      (cmdDone),
    .busReset     (busReset),
    .cfgWrite     (cfgWrite),
    .intrSet      (statusOut[INTR_POS]),
    .deferPending (deferPending),
    .reportOff    (cfg1Out[RPT_OFF_POS]),
    .stb          (stb)
  );

  intr_status_dp #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .evtCause     (evtCause),
    .evtStatus    (evtStatus),
    .evtSeq       (evtSeq),
    .cmdByte      (cmdByte),
    .cfgData      (cfgData),
    .irqOut       (irqOut),
    .causeReg     (causeOut),
    .statusReg    (statusOut),
    .seqReg       (seqOut),
    .cfg1Reg      (cfg1Out),
    .readReg      (readData),
    .doneReg      (doneStatus),
    .deferPending (deferPending)
  );

endmodule

// File: rtl/intr_status_checker.sv
module intr_status_checker
  import intr_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEQ_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostRd,
  input logic              cmdDone,
  input logic              busReset,
  input logic              irqOut,
  input logic [DATA_W-1:0] causeOut,
  input logic [DATA_W-1:0] statusOut,
  input logic [SEQ_W-1:0]  seqOut,
  input logic [DATA_W-1:0] cfg1Out,
  input logic [DATA_W-1:0] readData,
  input logic              deferPending
);

  p_irq_mirror_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == statusOut[INTR_POS]);

  p_read_returns_old_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> (readData == $past(causeOut)) && (causeOut == '0));

  p_read_side_effects_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> !irqOut && !statusOut[TC_POS] && (seqOut == SEQ_W'(SEQ_CMD_DONE)));

  p_direct_complete_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDone && !irqOut && !hostRd && !deferPending) |=>
      irqOut && (causeOut == DATA_W'(CAUSE_SERVICE)) &&
      (statusOut == (DATA_W'(STATUS_DONE) | (DATA_W'(1) << INTR_POS))) &&
      (seqOut == '0));

  p_replay_after_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && cmdDone ##1 !hostRd) |=>
      irqOut && (causeOut == DATA_W'(CAUSE_SERVICE)));

  p_busrst_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !hostRd && !deferPending && !cmdDone && cfg1Out[RPT_OFF_POS]) |=>
      (causeOut == DATA_W'(CAUSE_BUS_RST)) && (irqOut == $past(irqOut)));

endmodule

bind intr_status_unit intr_status_checker #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .hostRd       (hostRd),
  .cmdDone      (cmdDone),
  .busReset     (busReset),
  .irqOut       (irqOut),
  .causeOut     (causeOut),
  .statusOut    (statusOut),
  .seqOut       (seqOut),
  .cfg1Out      (cfg1Out),
  .readData     (readData),
  .deferPending (deferPending)
);

// File: tb/intr_status_unit_test.sv
module intr_status_unit_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostRd = 1'b0, evtLoad = 1'b0, evtRaise = 1'b0;
  logic [7:0] evtCause = '0, evtStatus = '0;
  logic [2:0] evtSeq = '0;
  logic       cmdDone = 1'b0;
  logic [7:0] cmdByte = '0;
  logic       busReset = 1'b0, cfgWrite = 1'b0;
  logic [7:0] cfgData = '0;
  logic       irqOut;
  logic [7:0] causeOut, statusOut, cfg1Out, readData, doneStatus;
  logic [2:0] seqOut;

  always #10 clk = ~clk;  // 50 MHz

  intr_status_unit uut (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .evtLoad(evtLoad), .evtRaise(evtRaise),
    .evtCause(evtCause), .evtStatus(evtStatus), .evtSeq(evtSeq), .cmdDone(cmdDone),
    .cmdByte(cmdByte), .busReset(busReset), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .irqOut(irqOut), .causeOut(causeOut), .statusOut(statusOut), .seqOut(seqOut),
    .cfg1Out(cfg1Out), .readData(readData), .doneStatus(doneStatus)
  );

  typedef struct {
    logic [7:0] cause, status, cfg, rd, done;
    logic [2:0] seq;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;

  // reference state built from the requirements
  logic [7:0] mCause = '0, mStatus = '0, mCfg = 8'h07, mRd = '0, mDone = '0, mPark = '0;
  logic [2:0] mSeq = '0;
  logic       mIrq = 1'b0, mDefer = 1'b0;

  task automatic compare(input exp_t e);
    checks++;
    if (causeOut !== e.cause || statusOut !== e.status || seqOut !== e.seq ||
        irqOut !== e.irq || cfg1Out !== e.cfg || readData !== e.rd || doneStatus !== e.done) begin
      fails++;
      $display("FAIL %s: actual cause=%h status=%h seq=%0d irq=%b cfg=%h rd=%h done=%h expected cause=%h status=%h seq=%0d irq=%b cfg=%h rd=%h done=%h",
               e.tag, causeOut, statusOut, seqOut, irqOut, cfg1Out, readData, doneStatus,
               e.cause, e.status, e.seq, e.irq, e.cfg, e.rd, e.done);
    end
  endtask

  // monitor: compares one queued item 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  // driver: one cycle of stimulus and the predicted state after the next edge
  task automatic step(input string tag, input logic rd, input logic ld, input logic rs,
                      input logic [7:0] lc, input logic [7:0] ls, input logic [2:0] lq,
                      input logic cd, input logic [7:0] cb, input logic br,
                      input logic cw, input logic [7:0] cv);
    logic rep, comp, latch, bre, lde, raise;
    exp_t e;
    @(negedge clk);
    hostRd = rd; evtLoad = ld; evtRaise = rs; evtCause = lc; evtStatus = ls; evtSeq = lq;
    cmdDone = cd; cmdByte = cb; busReset = br; cfgWrite = cw; cfgData = cv;

    rep   = !rd && mDefer && !mStatus[7];                 // R9
    comp  = !rd && !mDefer && !mStatus[7] && cd;          // R7
    latch = cd && !comp;                                  // R8
    bre   = !rd && !rep && !comp && br;                   // R6, R10
    lde   = !rd && !rep && !comp && !br && ld;            // R2, R6
    raise = rep || comp || (bre && !mCfg[6]) || (lde && rs);
    if (rd) begin                                         // R4, R5
      mRd = mCause; mCause = '0; mStatus[7] = 1'b0; mStatus[4] = 1'b0;
      mSeq = 3'd4; mIrq = 1'b0;
    end else if (rep || comp) begin
      mStatus = 8'h13 | (mStatus & 8'h80); mCause = 8'h10; mSeq = '0;
      mDone = rep ? mPark : cb;
    end else if (bre) begin
      mCause = 8'h80;
    end else if (lde) begin
      mCause = lc; mStatus = (ls & 8'h7f) | (mStatus & 8'h80); mSeq = lq;
    end
    if (raise && !mStatus[7]) begin mStatus[7] = 1'b1; mIrq = 1'b1; end  // R3
    if (rep) mDefer = 1'b0;
    if (latch) begin mDefer = 1'b1; mPark = cb; end
    if (cw) mCfg = cv;                                    // R11

    e.cause = mCause; e.status = mStatus; e.seq = mSeq; e.irq = mIrq;
    e.cfg = mCfg; e.rd = mRd; e.done = mDone; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 8'h00, 8'h00, 3'd0, 0, 8'h00, 0, 0, 8'h00);
  endtask

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.cause = '0; r.status = '0; r.seq = '0; r.irq = 1'b0;
    r.cfg = 8'h07; r.rd = '0; r.done = '0; r.tag = "R1 reset state";
    compare(r);
    rstN = 1'b1;

    step("R11 cfg write with report disabled", 0,0,0, 8'h00,8'h00,3'd0, 0,8'h00, 0, 1,8'h47);
    step("R10 bus reset masked",              0,0,0, 8'h00,8'h00,3'd0, 0,8'h00, 1, 0,8'h00);
    step("R11 cfg write report enabled",      0,0,0, 8'h00,8'h00,3'd0, 0,8'h00, 0, 1,8'h07);
    step("R10 bus reset raises",              0,0,0, 8'h00,8'h00,3'd0, 0,8'h00, 1, 0,8'h00);
    step("R4 read returns reset cause",       1,0,0, 8'h00,8'h00,3'd0, 0,8'h00, 0, 0,8'h00);
    step("R2 load with raise",                0,1,1, 8'h28,8'h12,3'd2, 0,8'h00, 0, 0,8'h00);
    step("R3 raise while pending",            0,1,1, 8'h08,8'h91,3'd1, 0,8'h00, 0, 0,8'h00);
    step("R5 read clears pending and TC",     1,0,0, 8'h00,8'h00,3'd0, 0,8'h00, 0, 0,8'h00);
    step("R2 load without raise",             0,1,0, 8'h04,8'hE6,3'd3, 0,8'h00, 0, 0,8'h00);
    step("R7 direct completion",              0,0,0, 8'h00,8'h00,3'd0, 1,8'h02, 0, 0,8'h00);
    step("R8 completion parked while pending",0,0,0, 8'h00,8'h00,3'd0, 1,8'h55, 0, 0,8'h00);
    idle("R8 parked completion stays hidden");
    step("R5 read before replay",             1,0,0, 8'h00,8'h00,3'd0, 0,8'h00, 0, 0,8'h00);
    idle("R9 replay of parked completion");
    step("R6 load dropped during read",       1,1,1, 8'hAA,8'h05,3'd6, 0,8'h00, 0, 0,8'h00);
    idle("R6 state after dropped load");
    step("R2 load raise before mixed read",   0,1,1, 8'h20,8'h01,3'd1, 0,8'h00, 0, 0,8'h00);
    step("R8 completion with read same cycle",1,0,0, 8'h00,8'h00,3'd0, 1,8'h3C, 0, 0,8'h00);
    idle("R9 replay after mixed read");
    step("R6 bus reset dropped during read",  1,0,0, 8'h00,8'h00,3'd0, 0,8'h00, 1, 0,8'h00);
    idle("R6 no cause after dropped reset");
    idle("R4 readData holds");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule